// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a 12-bit serial analog-to-digital converter that has only a data output line. It owns the active-low chip select, which also puts the converter into low-power standby while it is high. It also generates the data clock from the system clock through a programmable divider. A start pulse opens a frame by pulling chip select low. The controller clocks through the acquisition interval, skips the leading null bit and shifts in the result most significant bit first.

In single mode, chip select goes high right after the last result bit, so the converter drops into standby. In dual mode, chip select stays low for 11 more bits. Over those bits the converter repeats the word least significant bit first, and the LSB is shared between the two copies. The controller rebuilds the second copy and flags a mismatch when it differs from the first. The result goes out unchanged as a two's complement word with a one-cycle valid strobe. A start request that arrives during a frame is held and served once chip select has been high for at least one data-clock period.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: During and after reset, cs_n_o is 1, dclk_o is 0, and busy_o, valid_o, mismatch_o and result_o are all 0.
- R2: A start_i pulse while idle drives cs_n_o low and busy_o high on the next clock edge. dclk_o is 0 whenever cs_n_o is 1, and busy_o is 1 whenever cs_n_o is 0.
- R3: Each data-clock half period lasts div_i+1 system cycles, with div_i captured when the frame starts. The first rising edge of dclk_o comes div_i+1 cycles after cs_n_o falls.
- R4: A single-mode frame (dual_i=0 at start) has ACQ_CYC+1+12 rising data-clock edges, which is 16 with the defaults. The word is sampled at rising edges ACQ_CYC+2 through ACQ_CYC+13, most significant bit first. The levels seen at the acquisition edges and at the null-bit edge have no effect on the result.
- R5: A dual-mode frame has ACQ_CYC+24 rising edges, which is 27 with the defaults. The 11 bits sampled at edges ACQ_CYC+14 to ACQ_CYC+24 are result bits 1 through 11 in that order, and bit 0 of the second copy is taken from the first copy.
- R6: mismatch_o is updated with each valid_o. It is 1 only in dual mode when the rebuilt second copy differs from the first copy, and it is always 0 in single mode. In both cases result_o carries the first copy.
- R7: valid_o is a one-cycle pulse that rises on the same edge as cs_n_o. result_o and mismatch_o hold their values until the next valid_o.
- R8: Between two frames, cs_n_o stays high for at least 2*(div+1) system cycles.
- R9: A start request while busy_o is 1 is held and starts exactly one further frame after the current one, however many pulses arrived. With no request pending, cs_n_o stays high.
- R10: result_o is the 12-bit two's complement code exactly as received: 0x800 is negative full scale, 0x000 is midscale and 0x7FF is positive full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request pulse |
| dual_i | input | 1 | 1 selects dual readout with reversed-copy check |
| div_i | input | DIV_W | Data-clock half period minus one, in system cycles |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select; high puts the converter in standby |
| dclk_o | output | 1 | Data clock to the converter, idle low |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| result_o | output | DATA_W | Last two's complement result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| mismatch_o | output | 1 | Reversed copy differed from the forward copy |

## Verification
The converter model drives 1 during acquisition and high impedance (read as 1) past the reversed copy. A controller that samples at the wrong edge index therefore returns a shifted or polluted word, and the extreme codes 0x800 and 0x7FF make that shift visible. The model can corrupt a single bit of the reversed copy. A design that compares in single mode, ignores the reversal order or never sets the flag shows the wrong mismatch value. Back-to-back start pulses sent during a frame check that requests are held and merged. A design that drops the held request, or runs it twice, produces a missing or an extra frame. The bench also measures the chip-select high time and the data-clock half periods, which exposes an off-by-one in the divider or the gap.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

    localparam int RES_W_DEF = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;

    // Event bundle passed from the sequencer to the capture datapath.
    typedef struct packed {
        logic samp;   // rising data-clock edge: sample the line now
        logic done;   // last falling edge of the frame
        logic dual;   // frame runs in dual readout
    } seq_evt_t;

    // Number of rising data-clock edges in a frame.
    function automatic int frame_edges(input int acq, input int w, input bit dual);
        return acq + 1 + w + (dual ? (w - 1) : 0);
    endfunction

endpackage

// File: rtl/adc_rdout_tick.sv
module adc_rdout_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == div);

endmodule

// File: rtl/adc_rdout_seq.sv
module adc_rdout_seq
    import adc_rdout_pkg::*;
#(
    parameter int DATA_W  = RES_W_DEF,
    parameter int ACQ_CYC = 3,
    parameter int DIV_W   = 8,
    parameter int CNT_W   = $clog2(frame_edges(ACQ_CYC, DATA_W, 1'b1) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dual_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             cs_n,
    output logic             dclk,
    output logic             busy,
    output seq_evt_t         evt,
    output logic [CNT_W-1:0] samp_idx,
    output logic [DIV_W-1:0] div_q
);

    localparam logic [CNT_W-1:0] LAST_SGL  = CNT_W'(frame_edges(ACQ_CYC, DATA_W, 1'b0));
    localparam logic [CNT_W-1:0] LAST_DUAL = CNT_W'(frame_edges(ACQ_CYC, DATA_W, 1'b1));

    seq_st_e          st;
    logic             pend;
    logic             dual_q;
    logic             gap_half;
    logic [CNT_W-1:0] edge_cnt;
    logic             tick;
    logic             launch;
    logic             at_last;

    adc_rdout_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (st != ST_IDLE),
        .div  (div_q),
        .tick (tick)
    );

    assign launch   = (st == ST_IDLE) && (start_i || pend);
    assign at_last  = edge_cnt == (dual_q ? LAST_DUAL : LAST_SGL);
    assign samp_idx = edge_cnt + 1'b1;
    assign busy     = st != ST_IDLE;

    always_comb begin
        evt.samp = (st == ST_RUN) && tick && !dclk;
        evt.done = (st == ST_RUN) && tick && dclk && at_last;
        evt.dual = dual_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pend     <= 1'b0;
            dual_q   <= 1'b0;
            div_q    <= '0;
            gap_half <= 1'b0;
            edge_cnt <= '0;
            cs_n     <= 1'b1;
            dclk     <= 1'b0;
        end else begin
            if (launch) begin
                pend <= 1'b0;
            end else if (start_i) begin
                pend <= 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (launch) begin
                        cs_n     <= 1'b0;
                        st       <= ST_RUN;
                        edge_cnt <= '0;
                        dual_q   <= dual_i;
                        div_q    <= div_i;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (!dclk) begin
                            dclk     <= 1'b1;
                            edge_cnt <= edge_cnt + 1'b1;
                        end else begin
                            dclk <= 1'b0;
                            if (at_last) begin
                                cs_n     <= 1'b1;
                                st       <= ST_GAP;
                                gap_half <= 1'b0;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            st <= ST_IDLE;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_rdout_cap.sv
module adc_rdout_cap
    import adc_rdout_pkg::*;
#(
    parameter int DATA_W  = RES_W_DEF,
    parameter int ACQ_CYC = 3,
    parameter int CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_t          evt,
    input  logic [CNT_W-1:0]  samp_idx,
    input  logic              sdo,
    output logic [DATA_W-1:0] result,
    output logic              valid,
    output logic              mismatch
);

    localparam logic [CNT_W-1:0] FWD_LO = CNT_W'(ACQ_CYC + 2);
    localparam logic [CNT_W-1:0] FWD_HI = CNT_W'(ACQ_CYC + 1 + DATA_W);
    localparam logic [CNT_W-1:0] REV_LO = CNT_W'(ACQ_CYC + 2 + DATA_W);
    localparam logic [CNT_W-1:0] REV_HI = CNT_W'(ACQ_CYC + 2 * DATA_W);

    logic [DATA_W-1:0] fwd_sr;
    logic [DATA_W-2:0] rev_sr;
    logic              in_fwd;
    logic              in_rev;
    logic [DATA_W-1:0] rev_word;

    assign in_fwd   = (samp_idx >= FWD_LO) && (samp_idx <= FWD_HI);
    assign in_rev   = (samp_idx >= REV_LO) && (samp_idx <= REV_HI);
    assign rev_word = {rev_sr, fwd_sr[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_sr <= '0;
            rev_sr <= '0;
        end else if (evt.samp) begin
            if (in_fwd) begin
                fwd_sr <= {fwd_sr[DATA_W-2:0], sdo};
            end
            if (in_rev) begin
                rev_sr <= {sdo, rev_sr[DATA_W-2:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            valid    <= 1'b0;
            mismatch <= 1'b0;
        end else begin
            valid <= evt.done;
            if (evt.done) begin
                result   <= fwd_sr;
                mismatch <= evt.dual && (rev_word != fwd_sr);
            end
        end
    end

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
    import adc_rdout_pkg::*;
#(
    parameter int DATA_W  = RES_W_DEF,
    parameter int ACQ_CYC = 3,
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dual_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              dclk_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              mismatch_o
);

    localparam int CNT_W = $clog2(frame_edges(ACQ_CYC, DATA_W, 1'b1) + 1);

    seq_evt_t         evt;
    logic [CNT_W-1:0] samp_idx;
    logic [DIV_W-1:0] div_q;

    adc_rdout_seq #(
        .DATA_W  (DATA_W),
        .ACQ_CYC (ACQ_CYC),
        .DIV_W   (DIV_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .dual_i   (dual_i),
        .div_i    (div_i),
        .cs_n     (cs_n_o),
        .dclk     (dclk_o),
        .busy     (busy_o),
        .evt      (evt),
        .samp_idx (samp_idx),
        .div_q    (div_q)
    );

    adc_rdout_cap #(
        .DATA_W  (DATA_W),
        .ACQ_CYC (ACQ_CYC),
        .CNT_W   (CNT_W)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .samp_idx (samp_idx),
        .sdo      (sdo_i),
        .result   (result_o),
        .valid    (valid_o),
        .mismatch (mismatch_o)
    );

endmodule

// File: rtl/adc_rdout_chk.sv
module adc_rdout_chk #(
    parameter int DATA_W = 12,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n_o,
    input logic              dclk_o,
    input logic              busy_o,
    input logic              valid_o,
    input logic              mismatch_o,
    input logic [DATA_W-1:0] result_o,
    input logic [DIV_W-1:0]  div_q
);

    localparam int GW = DIV_W + 3;

    logic [GW-1:0] gap_cnt;
    logic          seen_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt  <= '0;
            seen_end <= 1'b0;
        end else begin
            if (valid_o) seen_end <= 1'b1;
            if (!cs_n_o) begin
                gap_cnt <= '0;
            end else if (gap_cnt != {GW{1'b1}}) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    AST_DCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !dclk_o); // R2

    AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> busy_o); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R7

    AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $rose(cs_n_o)); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |=> ($stable(result_o) || valid_o)); // R7

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |=> ($stable(mismatch_o) || valid_o)); // R6

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        (seen_end && $fell(cs_n_o)) |-> ((32'(gap_cnt) + 1) >= 2 * (32'(div_q) + 1))); // R8

endmodule

bind adc_rdout_ctrl adc_rdout_chk #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n_o     (cs_n_o),
    .dclk_o     (dclk_o),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .mismatch_o (mismatch_o),
    .result_o   (result_o),
    .div_q      (div_q)
);

// File: tb/adc_rdout_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rdout_ctrl_tb_top;

    localparam int W   = 12;
    localparam int ACQ = 3;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          dual_i = 1'b0;
    logic [DW-1:0] div_i = '0;
    logic          sdo_i;
    logic          cs_n_o, dclk_o, busy_o, valid_o, mismatch_o;
    logic [W-1:0]  result_o;

    int vectors = 0;
    int miscompares = 0;
    int idle_clk_bad = 0;

    // converter model state
    logic [W-1:0] mdl_word = '0;
    int           mdl_flip = 0;   // 0: none, 1..11: corrupt that bit of the reversed copy
    int           fall_n = 0;
    int           rise_n = 0;

    always #10 clk = ~clk;

    adc_rdout_ctrl #(.DATA_W(W), .ACQ_CYC(ACQ), .DIV_W(DW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dual_i     (dual_i),
        .div_i      (div_i),
        .sdo_i      (sdo_i),
        .cs_n_o     (cs_n_o),
        .dclk_o     (dclk_o),
        .busy_o     (busy_o),
        .result_o   (result_o),
        .valid_o    (valid_o),
        .mismatch_o (mismatch_o)
    );

    function automatic logic mdl_bit(input int n);
        int k;
        k = n - (ACQ + 1);
        if (n <= ACQ) return 1'b1;          // acquisition: junk level
        if (k == 0) return 1'b0;            // null bit
        if (k <= W) return mdl_word[W - k];
        if (k <= 2 * W - 1) return mdl_word[k - W] ^ (mdl_flip == (k - W));
        return 1'b1;                        // released line pulled high
    endfunction

    always @(negedge cs_n_o) begin
        fall_n = 0;
        rise_n = 0;
    end
    always @(negedge dclk_o) if (!cs_n_o) fall_n = fall_n + 1;
    always @(posedge dclk_o) rise_n = rise_n + 1;
    assign sdo_i = mdl_bit(fall_n + 1);

    always @(negedge clk) if (!rst && cs_n_o && dclk_o) idle_clk_bad++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (valid_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // One full frame with checks on timing, edge count and result.
    task automatic run_frame(input logic [W-1:0] word, input bit dual, input int flip,
                             input int dv, input string req);
        int  c;
        bit  seen;
        int  exp_edges;
        mdl_word = word;
        mdl_flip = flip;
        dual_i   = dual;
        div_i    = DW'(dv);
        pulse_start();
        chk(cs_n_o == 1'b0 && busy_o == 1'b1, "R2", "select and busy after start",
            {cs_n_o, busy_o}, 2'b01);
        dual_i = 1'b0;
        div_i  = '0;           // changes after start must not matter (R3)
        c = 0;
        while (dclk_o == 1'b0 && c < 1000) begin c++; @(negedge clk); end
        chk(c == dv + 1, "R3", "cycles to first rising edge", c, dv + 1);
        c = 0;
        while (dclk_o == 1'b1 && c < 1000) begin c++; @(negedge clk); end
        chk(c == dv + 1, "R3", "high half period", c, dv + 1);
        wait_valid(seen);
        chk(seen, "R7", "valid seen", seen, 1);
        chk(cs_n_o == 1'b1, "R7", "select released with valid", cs_n_o, 1);
        exp_edges = ACQ + 1 + W + (dual ? W - 1 : 0);
        chk(rise_n == exp_edges, dual ? "R5" : "R4", "rising edge count", rise_n, exp_edges);
        chk(result_o == word, req, "result word", result_o, word);
        chk(mismatch_o == (dual && flip != 0), "R6", "mismatch flag",
            mismatch_o, (dual && flip != 0));
        @(negedge clk);
        chk(valid_o == 1'b0, "R7", "valid lasts one cycle", valid_o, 0);
        repeat (5) @(negedge clk);
        chk(result_o == word, "R7", "result held", result_o, word);
        while (busy_o) @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1 && dclk_o == 0 && busy_o == 0 && valid_o == 0, "R1",
            "control outputs in reset", {cs_n_o, dclk_o, busy_o, valid_o}, 4'b1000);
        chk(result_o == 0 && mismatch_o == 0, "R1", "data outputs in reset",
            {mismatch_o, result_o}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(cs_n_o == 1 && busy_o == 0, "R1", "idle after reset", {cs_n_o, busy_o}, 2'b10);
    endtask

    task automatic test_single();
        run_frame(12'h5A3, 1'b0, 0, 0, "R4");
        run_frame(12'h800, 1'b0, 0, 1, "R10");
        run_frame(12'h7FF, 1'b0, 0, 3, "R10");
        run_frame(12'h000, 1'b0, 0, 2, "R10");
        run_frame(12'h3C6, 1'b0, 5, 1, "R6");   // corrupt copy never read in single mode
    endtask

    task automatic test_dual();
        run_frame(12'hA5C, 1'b1, 0, 2, "R5");
        run_frame(12'h801, 1'b1, 0, 0, "R5");
        run_frame(12'h6B2, 1'b1, 7, 1, "R6");
        run_frame(12'h7FE, 1'b1, 11, 0, "R6");
        run_frame(12'h00F, 1'b1, 0, 1, "R6");   // flag clears on a clean frame
    endtask

    task automatic test_back_to_back();
        bit seen;
        int gap;
        int extra;
        mdl_word = 12'h2E7;
        mdl_flip = 0;
        dual_i   = 1'b0;
        div_i    = DW'(1);
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (4) @(negedge clk);
        pulse_start();
        wait_valid(seen);
        chk(seen && result_o == 12'h2E7, "R9", "first queued frame result", result_o, 12'h2E7);
        mdl_word = 12'h915;
        gap = 0;
        while (cs_n_o == 1'b1 && gap < 1000) begin gap++; @(negedge clk); end
        chk(gap >= 4 && gap < 1000, "R8", "select high between frames", gap, 4);
        wait_valid(seen);
        chk(seen && result_o == 12'h915, "R9", "held request frame result", result_o, 12'h915);
        extra = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!cs_n_o) extra++;
        end
        chk(extra == 0, "R9", "no third frame from merged requests", extra, 0);
        chk(idle_clk_bad == 0, "R2", "data clock quiet while deselected", idle_clk_bad, 0);
    endtask

    initial begin
        #(20ns * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_single();
        test_dual();
        test_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule